// File: doc/BRIEF.md
# Framed Pseudo-Random and Repetitive Pattern Checker

This block watches a serial test stream, one bit per clock at most, and decides whether it carries the pattern it was told to expect. The pattern is either a fixed word of 2 to 32 bits that repeats, or a pseudo-random sequence built from a feedback recurrence of programmable length and tap. Each bit comes with a valid strobe and a flag that marks it as part of the test timeslot. In framed operation only flagged bits are examined. In unframed operation every valid bit is examined.

The checker first hunts for alignment with the stream. Once it has seen a long enough run of correct bits it declares sync. It then flags every wrong bit and drops sync when errors in a recent window grow too dense. Recovery is either automatic or waits for a rising edge on a manual control. Two saturating counters run alongside: one counts examined bits and one counts errors. A 32-bit snapshot register captures one of them, or the most recent received bits. The capture happens on an interval tick, a direct write strobe or a global update strobe. Transfer and overrun flags show whether the software has read each snapshot in time.

Top module: `prbs_mon`

## Requirements
- R1: A bit is qualified when `bit_valid` is 1 and either `framed_en` is 0 or `ts_flag` is 1. Unqualified bits change no state and are not counted.
- R2: With `invert_en` = 1 each received bit is complemented before any comparison, count or capture.
- R3: Pseudo-random mode (`prbs_sel` = 1): the stream obeys s[n] = s[n-L] xor s[n-T], with L = `len_m1`+1 (2..32) and T = `tap_m1`+1 (1..L-1). After a search starts, the first L qualified bits seed the checker. It then predicts every later bit, and `in_sync` rises on the cycle after the 48th consecutive correct prediction, that is, after qualified bit L+48.
- R4: Repetitive mode (`prbs_sel` = 0): the stream is `pat_word` bit 0 first through bit L-1, repeated. During search a mismatch slips the checker's alignment by one bit. Sync needs 48 consecutive matching bits, so `in_sync` never rises before 48 qualified bits have arrived since the search began.
- R5: While in sync, every mismatched qualified bit gives a one-cycle `bit_err` pulse on the following cycle. The expected sequence is generated locally once in sync, so one corrupted bit gives exactly one pulse.
- R6: The window covers the last 48 qualified bits since sync was declared. The bit that brings the window's error total above 10 clears `in_sync`. A total of exactly 10 keeps sync.
- R7: With `auto_resync` = 1, losing sync starts a new search at once, and sync returns after L+48 further correct bits in pseudo-random mode.
- R8: With `auto_resync` = 0 the checker stays out of sync until `man_sync` rises. Any rising edge of `man_sync`, even while in sync, clears `in_sync` and restarts the search. Holding it high does not restart again.
- R9: A snapshot is taken on any cycle where `interval_tick`, `snap_wr` or `glob_upd` is 1, and it appears on `snap_data` on the next cycle. `snap_sel` picks the content: 0 gives the last 32 qualified bits after inversion, newest in bit 0; 1 gives the error count; 2 gives the qualified-bit count; 3 gives zero.
- R10: The error counter counts R5 events. The bit counter counts qualified bits in any sync state. Both restart from zero at each snapshot and stop at 2^CNT_W-1 instead of wrapping.
- R11: `xfer_flag` is set by every snapshot and cleared by `snap_rd` when no snapshot occurs in the same cycle.
- R12: `ovr_flag` is set when a snapshot occurs while `xfer_flag` is 1 and `snap_rd` is 0. A read clears it. A read in the same cycle as a snapshot leaves `xfer_flag` = 1 and `ovr_flag` = 0.
- R13: After reset `in_sync`, `bit_err`, `xfer_flag`, `ovr_flag` and `snap_data` are all zero and a search is under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | Strobe marking a stream bit |
| bit_data | input | 1 | Stream bit |
| ts_flag | input | 1 | Bit belongs to the test timeslot |
| framed_en | input | 1 | 1: check flagged bits only |
| prbs_sel | input | 1 | 1: pseudo-random, 0: repetitive |
| invert_en | input | 1 | Complement received bits |
| len_m1 | input | LEN_W | Pattern length minus one |
| tap_m1 | input | LEN_W | Feedback tap minus one |
| pat_word | input | MAX_LEN | Repetitive word |
| auto_resync | input | 1 | Search again automatically after loss |
| man_sync | input | 1 | Rising edge restarts search |
| snap_sel | input | 2 | Snapshot content select |
| interval_tick | input | 1 | Periodic snapshot request |
| snap_wr | input | 1 | Direct snapshot write strobe |
| glob_upd | input | 1 | Global update strobe |
| snap_rd | input | 1 | Snapshot read strobe |
| in_sync | output | 1 | Sync status |
| bit_err | output | 1 | Bit error pulse |
| snap_data | output | SNAP_W | Snapshot register |
| xfer_flag | output | 1 | New snapshot present |
| ovr_flag | output | 1 | Snapshot overwritten unread |

## Verification
The bench counts bits to the exact acquisition point. A detector that is off by one in seeding or in the run length rises one bit early or late. It also drives the window to exactly 10 and then 11 errors, so a comparison against the wrong threshold shows up as early or missing loss. A self-synchronising detector would triple each injected error and fail the single-pulse check. Garbage bits without the timeslot flag, random gaps, a held manual control and a read that collides with a snapshot probe qualification, edge detection and flag priority. A 300-bit run against an 8-bit counter shows whether the counter wraps.

// File: rtl/prbs_mon_pkg.sv
`timescale 1ns/1ps
package prbs_mon_pkg;

    // Search / locked / waiting for manual restart
    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_WAIT   = 2'd1,
        ST_LOCK   = 2'd2
    } sync_st_e;

    // Snapshot content select
    typedef enum logic [1:0] {
        SEL_PAT  = 2'd0,
        SEL_ERR  = 2'd1,
        SEL_BITS = 2'd2,
        SEL_NONE = 2'd3
    } snap_sel_e;

    // One qualified stream bit after inversion
    typedef struct packed {
        logic vld;
        logic dat;
    } qbit_t;

    // Snapshot update is requested by any of the three sources
    function automatic logic snap_request(input logic tick, input logic wr, input logic upd);
        return tick | wr | upd;
    endfunction

endpackage

// File: rtl/prbs_mon_satcnt.sv
`timescale 1ns/1ps
module prbs_mon_satcnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (clr) begin
            // a new interval starts with this cycle's event
            cnt <= W'(inc);
        end else if (inc && (cnt != '1)) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/prbs_mon_pred.sv
`timescale 1ns/1ps
module prbs_mon_pred
    import prbs_mon_pkg::*;
#(
    parameter  int MAX_LEN = 32,
    localparam int LEN_W   = $clog2(MAX_LEN)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               prbs_mode,
    input  logic [LEN_W-1:0]   len_m1,
    input  logic [LEN_W-1:0]   tap_m1,
    input  logic [MAX_LEN-1:0] rep_word,
    input  qbit_t              qb,
    input  logic               locked,
    input  logic               reseed,
    output logic               exp_bit,
    output logic               exp_ok
);

    logic [MAX_LEN-1:0] hist;
    logic [LEN_W:0]     seed_cnt;
    logic [LEN_W-1:0]   phase;
    logic [LEN_W:0]     len_full;
    logic               prbs_exp;
    logic               rep_exp;
    logic               seeded;

    assign len_full = {1'b0, len_m1} + (LEN_W+1)'(1);
    assign seeded   = (seed_cnt >= len_full);

    // recurrence s[n] = s[n-L] ^ s[n-T]; hist[k-1] holds s[n-k]
    assign prbs_exp = hist[len_m1] ^ hist[tap_m1];
    assign rep_exp  = rep_word[phase];

    assign exp_bit = prbs_mode ? prbs_exp : rep_exp;
    assign exp_ok  = prbs_mode ? seeded : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist     <= '0;
            seed_cnt <= '0;
            phase    <= '0;
        end else begin
            if (qb.vld) begin
                // locked: run as a free generator so errors are not multiplied
                hist <= {hist[MAX_LEN-2:0], (locked && prbs_mode) ? prbs_exp : qb.dat};
                // repetitive: hold phase on a search mismatch to slip one bit
                if (locked || (qb.dat == rep_exp)) begin
                    phase <= (phase >= len_m1) ? '0 : phase + 1'b1;
                end
            end
            if (reseed) begin
                seed_cnt <= '0;
            end else if (qb.vld && !seeded) begin
                seed_cnt <= seed_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/prbs_mon_sync.sv
`timescale 1ns/1ps
module prbs_mon_sync
    import prbs_mon_pkg::*;
#(
    parameter  int SYNC_RUN = 48,
    parameter  int WIN_LEN  = 48,
    parameter  int LOSS_TH  = 10,
    localparam int RUN_W    = $clog2(SYNC_RUN + 1),
    localparam int WCNT_W   = $clog2(WIN_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_vld,
    input  logic              chk_vld,
    input  logic              miss,
    input  logic              auto_en,
    input  logic              man_rise,
    output logic              in_sync,
    output logic              bit_err,
    output logic              err_evt,
    output logic              reseed,
    output logic [WCNT_W-1:0] win_errs
);

    sync_st_e          st;
    logic [RUN_W-1:0]  run;
    logic [WIN_LEN-1:0] win;
    logic [WCNT_W-1:0] errs_next;
    logic              lose;
    logic              run_done;

    // running window total: add the new bit, drop the one leaving
    assign errs_next = win_errs + WCNT_W'(miss) - WCNT_W'(win[WIN_LEN-1]);
    assign err_evt   = (st == ST_LOCK) && bit_vld && miss;
    assign lose      = err_evt && (errs_next > WCNT_W'(LOSS_TH));
    assign run_done  = (run == RUN_W'(SYNC_RUN - 1));
    assign reseed    = man_rise || (lose && auto_en);
    assign in_sync   = (st == ST_LOCK);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_SEARCH;
            run      <= '0;
            win      <= '0;
            win_errs <= '0;
            bit_err  <= 1'b0;
        end else begin
            bit_err <= err_evt;
            if (man_rise) begin
                st  <= ST_SEARCH;
                run <= '0;
            end else begin
                case (st)
                    ST_SEARCH: begin
                        if (chk_vld) begin
                            if (miss) begin
                                run <= '0;
                            end else if (run_done) begin
                                st       <= ST_LOCK;
                                run      <= '0;
                                win      <= '0;
                                win_errs <= '0;
                            end else begin
                                run <= run + 1'b1;
                            end
                        end
                    end
                    ST_LOCK: begin
                        if (bit_vld) begin
                            win      <= {win[WIN_LEN-2:0], miss};
                            win_errs <= errs_next;
                            if (lose) begin
                                st  <= auto_en ? ST_SEARCH : ST_WAIT;
                                run <= '0;
                            end
                        end
                    end
                    default: begin
                        // waiting for a manual restart edge
                        run <= '0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/prbs_mon_snap.sv
`timescale 1ns/1ps
module prbs_mon_snap
    import prbs_mon_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int SNAP_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  qbit_t             qb,
    input  logic              err_evt,
    input  logic              trig,
    input  logic              rd,
    input  logic [1:0]        sel,
    output logic [SNAP_W-1:0] snap_data,
    output logic              xfer,
    output logic              ovr
);

    localparam int NCNT = 2;

    logic [SNAP_W-1:0] rx_word;
    logic [SNAP_W-1:0] cand;
    logic [NCNT-1:0]   incs;
    logic [CNT_W-1:0]  cnts [NCNT];

    // index 0: errors, index 1: qualified bits
    assign incs = {qb.vld, err_evt};

    generate
        for (genvar i = 0; i < NCNT; i++) begin : g_cnt
            prbs_mon_satcnt #(.W(CNT_W)) u_cnt (
                .clk (clk),
                .rst (rst),
                .clr (trig),
                .inc (incs[i]),
                .cnt (cnts[i])
            );
        end
    endgenerate

    always_comb begin
        case (snap_sel_e'(sel))
            SEL_PAT:  cand = rx_word;
            SEL_ERR:  cand = SNAP_W'(cnts[0]);
            SEL_BITS: cand = SNAP_W'(cnts[1]);
            default:  cand = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_word   <= '0;
            snap_data <= '0;
            xfer      <= 1'b0;
            ovr       <= 1'b0;
        end else begin
            if (qb.vld) begin
                rx_word <= {rx_word[SNAP_W-2:0], qb.dat};
            end
            if (trig) begin
                snap_data <= cand;
            end
            if (trig) begin
                xfer <= 1'b1;
            end else if (rd) begin
                xfer <= 1'b0;
            end
            if (rd) begin
                ovr <= 1'b0;
            end
            if (trig && xfer && !rd) begin
                ovr <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/prbs_mon.sv
`timescale 1ns/1ps
module prbs_mon
    import prbs_mon_pkg::*;
#(
    parameter  int MAX_LEN  = 32,
    parameter  int CNT_W    = 32,
    parameter  int SNAP_W   = 32,
    parameter  int SYNC_RUN = 48,
    parameter  int WIN_LEN  = 48,
    parameter  int LOSS_TH  = 10,
    localparam int LEN_W    = $clog2(MAX_LEN),
    localparam int WCNT_W   = $clog2(WIN_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_valid,
    input  logic               bit_data,
    input  logic               ts_flag,
    input  logic               framed_en,
    input  logic               prbs_sel,
    input  logic               invert_en,
    input  logic [LEN_W-1:0]   len_m1,
    input  logic [LEN_W-1:0]   tap_m1,
    input  logic [MAX_LEN-1:0] pat_word,
    input  logic               auto_resync,
    input  logic               man_sync,
    input  logic [1:0]         snap_sel,
    input  logic               interval_tick,
    input  logic               snap_wr,
    input  logic               glob_upd,
    input  logic               snap_rd,
    output logic               in_sync,
    output logic               bit_err,
    output logic [SNAP_W-1:0]  snap_data,
    output logic               xfer_flag,
    output logic               ovr_flag
);

    qbit_t             qb;
    logic              man_prev;
    logic              man_rise;
    logic              exp_bit;
    logic              exp_ok;
    logic              miss;
    logic              reseed;
    logic              err_evt;
    logic              snap_trig;
    logic [WCNT_W-1:0] win_errs;

    always_comb begin
        qb.vld = bit_valid & (~framed_en | ts_flag);
        qb.dat = bit_data ^ invert_en;
    end

    assign miss      = qb.dat ^ exp_bit;
    assign man_rise  = man_sync & ~man_prev;
    assign snap_trig = snap_request(interval_tick, snap_wr, glob_upd);

    always_ff @(posedge clk) begin
        if (rst) begin
            man_prev <= 1'b0;
        end else begin
            man_prev <= man_sync;
        end
    end

    prbs_mon_pred #(.MAX_LEN(MAX_LEN)) u_pred (
        .clk       (clk),
        .rst       (rst),
        .prbs_mode (prbs_sel),
        .len_m1    (len_m1),
        .tap_m1    (tap_m1),
        .rep_word  (pat_word),
        .qb        (qb),
        .locked    (in_sync),
        .reseed    (reseed),
        .exp_bit   (exp_bit),
        .exp_ok    (exp_ok)
    );

    prbs_mon_sync #(
        .SYNC_RUN (SYNC_RUN),
        .WIN_LEN  (WIN_LEN),
        .LOSS_TH  (LOSS_TH)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .bit_vld  (qb.vld),
        .chk_vld  (qb.vld & exp_ok),
        .miss     (miss),
        .auto_en  (auto_resync),
        .man_rise (man_rise),
        .in_sync  (in_sync),
        .bit_err  (bit_err),
        .err_evt  (err_evt),
        .reseed   (reseed),
        .win_errs (win_errs)
    );

    prbs_mon_snap #(
        .CNT_W  (CNT_W),
        .SNAP_W (SNAP_W)
    ) u_snap (
        .clk       (clk),
        .rst       (rst),
        .qb        (qb),
        .err_evt   (err_evt),
        .trig      (snap_trig),
        .rd        (snap_rd),
        .sel       (snap_sel),
        .snap_data (snap_data),
        .xfer      (xfer_flag),
        .ovr       (ovr_flag)
    );

endmodule

// File: rtl/prbs_mon_chk.sv
`timescale 1ns/1ps
module prbs_mon_chk #(
    parameter int WCNT_W  = 6,
    parameter int LOSS_TH = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              bit_valid,
    input logic              man_sync,
    input logic              in_sync,
    input logic              bit_err,
    input logic              xfer_flag,
    input logic              ovr_flag,
    input logic              snap_rd,
    input logic              interval_tick,
    input logic              snap_wr,
    input logic              glob_upd,
    input logic [WCNT_W-1:0] win_errs
);

    logic trig;
    assign trig = interval_tick | snap_wr | glob_upd;

    // R5
    err_needs_sync_chk: assert property (@(posedge clk) disable iff (rst)
        bit_err |-> $past(in_sync));

    // R6
    window_bound_chk: assert property (@(posedge clk) disable iff (rst)
        in_sync |-> (win_errs <= WCNT_W'(LOSS_TH)));

    // R3
    acquire_on_bit_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(in_sync) |-> $past(bit_valid));

    // R8
    loss_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(in_sync) |-> ($past(bit_valid) || $past(man_sync)));

    // R11
    xfer_set_chk: assert property (@(posedge clk) disable iff (rst)
        trig |=> xfer_flag);

    // R12
    ovr_implies_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        ovr_flag |-> xfer_flag);

    // R12
    read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (snap_rd && !trig) |=> (!xfer_flag && !ovr_flag));

endmodule

bind prbs_mon prbs_mon_chk #(
    .WCNT_W  (WCNT_W),
    .LOSS_TH (LOSS_TH)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bit_valid     (bit_valid),
    .man_sync      (man_sync),
    .in_sync       (in_sync),
    .bit_err       (bit_err),
    .xfer_flag     (xfer_flag),
    .ovr_flag      (ovr_flag),
    .snap_rd       (snap_rd),
    .interval_tick (interval_tick),
    .snap_wr       (snap_wr),
    .glob_upd      (glob_upd),
    .win_errs      (win_errs)
);

// File: tb/prbs_mon_test.sv
`timescale 1ns/1ps
module prbs_mon_test;

    localparam int TB_CNT_W = 8;
    localparam int SAT      = (1 << TB_CNT_W) - 1;
    localparam int WD       = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_valid = 1'b0, bit_data = 1'b0, ts_flag = 1'b0;
    logic        framed_en = 1'b0, prbs_sel = 1'b1, invert_en = 1'b0;
    logic [4:0]  len_m1 = 5'd6, tap_m1 = 5'd5;
    logic [31:0] pat_word = 32'h0000_00B4;
    logic        auto_resync = 1'b1, man_sync = 1'b0;
    logic [1:0]  snap_sel = 2'd0;
    logic        interval_tick = 1'b0, snap_wr = 1'b0, glob_upd = 1'b0, snap_rd = 1'b0;
    logic        in_sync, bit_err, xfer_flag, ovr_flag;
    logic [31:0] snap_data;

    int          n_checks = 0;
    int          n_err = 0;
    bit          done = 0;

    // bench model state
    int          L = 7;
    int          T = 6;
    logic [31:0] g_hist = 32'h0000_005A;
    int          rep_idx = 0;
    int          m_bits = 0;
    int          last_bits = 0;
    logic [31:0] m_rx = '0;

    always #5 clk = ~clk;

    prbs_mon #(.CNT_W(TB_CNT_W)) uut (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_data(bit_data), .ts_flag(ts_flag),
        .framed_en(framed_en), .prbs_sel(prbs_sel), .invert_en(invert_en),
        .len_m1(len_m1), .tap_m1(tap_m1), .pat_word(pat_word),
        .auto_resync(auto_resync), .man_sync(man_sync), .snap_sel(snap_sel),
        .interval_tick(interval_tick), .snap_wr(snap_wr), .glob_upd(glob_upd), .snap_rd(snap_rd),
        .in_sync(in_sync), .bit_err(bit_err), .snap_data(snap_data),
        .xfer_flag(xfer_flag), .ovr_flag(ovr_flag)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic gen_bit();
        logic nb;
        nb = g_hist[L-1] ^ g_hist[T-1];
        g_hist = {g_hist[30:0], nb};
        return nb;
    endfunction

    function automatic logic rep_bit();
        logic b;
        b = pat_word[rep_idx];
        rep_idx = (rep_idx + 1) % L;
        return b;
    endfunction

    // b is the pattern bit; the line carries it inverted when invert_en is set
    task automatic send(input logic b, input logic ts);
        bit_valid = 1'b1;
        bit_data  = b ^ invert_en;
        ts_flag   = ts;
        if (!framed_en || ts) begin
            m_rx = {m_rx[30:0], b};
            if (m_bits < SAT) m_bits++;
        end
        @(negedge clk);
        bit_valid = 1'b0;
        ts_flag   = 1'b0;
    endtask

    task automatic send_prbs(input int n);
        for (int i = 0; i < n; i++) send(gen_bit(), 1'b1);
    endtask

    task automatic send_prbs_err(input int n);
        for (int i = 0; i < n; i++) send(~gen_bit(), 1'b1);
    endtask

    task automatic take(input logic [1:0] sel, input int src);
        snap_sel = sel;
        case (src)
            0:       snap_wr = 1'b1;
            1:       interval_tick = 1'b1;
            default: glob_upd = 1'b1;
        endcase
        @(negedge clk);
        snap_wr = 1'b0; interval_tick = 1'b0; glob_upd = 1'b0;
        last_bits = m_bits;
        m_bits = 0;
    endtask

    task automatic rd_snap();
        snap_rd = 1'b1;
        @(negedge clk);
        snap_rd = 1'b0;
    endtask

    task automatic restart();
        man_sync = 1'b1;
        @(negedge clk);
        man_sync = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R13 reset state
        check("R13", "in_sync", in_sync, 0);
        check("R13", "bit_err", bit_err, 0);
        check("R13", "xfer", xfer_flag, 0);
        check("R13", "ovr", ovr_flag, 0);
        check("R13", "snap", snap_data, 0);

        // R3 exact acquisition point, L=7 T=6
        send_prbs(L + 47);
        check("R3", "not yet in sync", in_sync, 0);
        send_prbs(1);
        check("R3", "in sync after L+48", in_sync, 1);
        take(2'd2, 0);
        check("R10", "bit count", snap_data, last_bits);
        check("R11", "xfer after snapshot", xfer_flag, 1);

        // R5 single error gives a single pulse
        send_prbs(5);
        send_prbs_err(1);
        check("R5", "err pulse", bit_err, 1);
        send_prbs(1);
        check("R5", "pulse ends", bit_err, 0);
        check("R5", "still in sync", in_sync, 1);
        take(2'd1, 1);
        check("R10", "error count one", snap_data, 1);
        check("R12", "overrun set", ovr_flag, 1);
        rd_snap();
        check("R11", "read clears xfer", xfer_flag, 0);
        check("R12", "read clears ovr", ovr_flag, 0);

        // R6 threshold: 10 keeps sync, 11 loses it
        send_prbs(60);
        send_prbs_err(10);
        check("R6", "ten errors keep sync", in_sync, 1);
        send_prbs_err(1);
        check("R6", "eleventh error drops sync", in_sync, 0);
        take(2'd1, 2);
        check("R10", "error count eleven", snap_data, 11);
        rd_snap();

        // R7 automatic search
        send_prbs(L + 47);
        check("R7", "auto not yet", in_sync, 0);
        send_prbs(1);
        check("R7", "auto regained", in_sync, 1);

        // R8 manual search
        auto_resync = 1'b0;
        send_prbs(40);
        send_prbs_err(11);
        check("R8", "lost", in_sync, 0);
        send_prbs(100);
        check("R8", "stays out without edge", in_sync, 0);
        man_sync = 1'b1;
        @(negedge clk);
        send_prbs(L + 47);
        check("R8", "manual not yet", in_sync, 0);
        send_prbs(1);
        check("R8", "manual regained with level held", in_sync, 1);
        man_sync = 1'b0;
        @(negedge clk);
        restart();
        check("R8", "edge drops sync", in_sync, 0);
        auto_resync = 1'b1;

        // R2 inversion
        invert_en = 1'b1;
        restart();
        send_prbs(L + 48);
        check("R2", "inverted stream syncs", in_sync, 1);
        take(2'd0, 0);
        check("R9", "pattern snapshot", snap_data, m_rx);
        rd_snap();
        invert_en = 1'b0;

        // R1 framed: unflagged garbage ignored, random gaps
        framed_en = 1'b1;
        restart();
        for (int i = 0; i < L + 48; i++) begin
            int ng;
            ng = $urandom_range(0, 3);
            for (int j = 0; j < ng; j++) send(1'($urandom_range(0, 1)), 1'b0);
            repeat ($urandom_range(0, 2)) @(negedge clk);
            send(gen_bit(), 1'b1);
            if (i == L + 46) check("R1", "framed not yet", in_sync, 0);
        end
        check("R1", "framed sync", in_sync, 1);
        take(2'd2, 1);
        check("R1", "flagged bits only counted", snap_data, last_bits);
        check("R1", "flagged count value", snap_data, L + 48);
        rd_snap();

        // R1 unframed: bits without the flag are checked
        framed_en = 1'b0;
        restart();
        for (int i = 0; i < L + 48; i++) send(gen_bit(), 1'b0);
        check("R1", "unframed sync ignores flag", in_sync, 1);

        // R4 repetitive word, stream starting mid-word
        prbs_sel = 1'b0;
        len_m1 = 5'd7;
        L = 8;
        rep_idx = 3;
        restart();
        for (int i = 0; i < 47; i++) send(rep_bit(), 1'b1);
        check("R4", "no sync before 48 bits", in_sync, 0);
        for (int i = 0; i < 200; i++) send(rep_bit(), 1'b1);
        check("R4", "repetitive sync", in_sync, 1);
        send(~rep_bit(), 1'b1);
        check("R5", "repetitive err pulse", bit_err, 1);
        send(rep_bit(), 1'b1);
        check("R5", "repetitive pulse ends", bit_err, 0);

        // R10 saturation and R9 pattern capture with random data
        take(2'd2, 1);
        rd_snap();
        for (int i = 0; i < 300; i++) send(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        take(2'd2, 2);
        check("R10", "bit count saturates", snap_data, SAT);
        check("R10", "model count", snap_data, last_bits);
        for (int i = 0; i < 40; i++) send(1'($urandom_range(0, 1)), 1'b1);
        take(2'd0, 0);
        check("R9", "last 32 bits", snap_data, m_rx);
        check("R12", "second snapshot overruns", ovr_flag, 1);

        // R12 read colliding with snapshot
        snap_sel = 2'd3;
        snap_rd = 1'b1;
        snap_wr = 1'b1;
        @(negedge clk);
        snap_rd = 1'b0;
        snap_wr = 1'b0;
        m_bits = 0;
        check("R12", "collide xfer", xfer_flag, 1);
        check("R12", "collide ovr", ovr_flag, 0);
        check("R9", "select three is zero", snap_data, 0);
        rd_snap();
        check("R11", "final read", xfer_flag, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule